// File: doc/BRIEF.md
# Entropy sample FIFO controller

The block buffers random words for software in a 64-entry, 64-bit FIFO. It draws on a bus of 128 free-running oscillator sample bits, arranged as sixteen groups of eight. A control register chooses the operating mode and the active group. In raw mode the block packs eight consecutive parallel samples from the chosen group into one word. In conditioned and deterministic modes it asks an external hash conditioner for a word, waits a fixed latency, and then takes the word the conditioner presents.

Production is demand driven. The FIFO is filled at reset and again whenever a read frees space, and the block stops producing as soon as the FIFO is full. Words are popped through a valid/ready read port, and the data arrives one cycle after the read is accepted. A registered built-in self-test status is also reported.

Top module: `ent_fifo_unit`

## Requirements
- R1: After reset the FIFO is empty, every control bit reads zero, no read data is flagged valid, the underflow flag is clear and no conditioner request is raised.
- R2: The control word layout is: bit0 run, bit1 source-on, bit2 raw-out, bit3 conditioner-reset, bit4 memory-reset, bits 8:5 group select. A write with either reset bit set zeroes the whole control register, empties the FIFO and clears the underflow flag. Both reset bits always read back as zero.
- R3: In raw mode (run=1, source-on=1, raw-out=1) with group g selected, the sample of input 8g+k taken in the j-th cycle of a word lands in word bit j*8+k.
- R4: In raw mode the first word enters the FIFO on the 8th clock edge after the control write, and one more word follows every 8 edges after that.
- R5: In conditioned mode (run=1, source-on=1, raw-out=0) cond_req stays high. The word on cond_word is pushed on the 81st edge after production starts, and cond_take is high in the cycle before that edge.
- R6: Deterministic mode (run=1, source-on=0) behaves as in R5 with cond_fixed high, and the oscillator inputs have no effect on the stored word.
- R7: The FIFO never holds more than 64 words. Once full, production stops, and reads free space that the block refills.
- R8: A read accepted on an edge gives rd_data_valid and the oldest word on the next cycle. Words leave in the order they entered.
- R9: A read of an empty FIFO returns zero and sets a sticky underflow flag, which stays set until a reset-bit write.
- R10: Any control write during a partly packed raw word discards that word, so the next word holds only samples taken after the write.
- R11: bist_stat presents bist_raw one cycle later, so a passing self-test reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 9 | Control word to write |
| cfg_rdata | output | 9 | Current control register |
| osc_in | input | 128 | One sample bit per oscillator per cycle |
| rd_valid | input | 1 | Read request |
| rd_ready | output | 1 | Read request accepted (always high) |
| rd_data | output | 64 | Popped word, zero on underflow |
| rd_data_valid | output | 1 | rd_data belongs to the read accepted one cycle earlier |
| fill_level | output | 7 | Words held in the FIFO |
| underflow | output | 1 | Sticky empty-read flag |
| cond_req | output | 1 | Conditioner word requested |
| cond_fixed | output | 1 | Conditioner must use fixed inputs |
| cond_take | output | 1 | cond_word is captured at the coming edge |
| cond_word | input | 64 | Word from the external conditioner |
| bist_raw | input | 8 | Raw self-test result bits |
| bist_stat | output | 8 | Registered self-test status |

## Verification
The bench drives a distinct byte pattern on the selected group and the inverse pattern on every other group. A design that swaps sample order inside a word, or reads the wrong group, therefore stores a visibly different word. It samples the fill level on the exact edges of R4 and R5, one cycle early and on time, which catches an off-by-one latency counter. It fills the FIFO, then reads three words and waits, so a refill that overshoots 64 or never restarts is exposed. A control write halfway through a word shows whether the stale half-word leaks out, and an empty read shows whether the flag is sticky and whether the returned data is zeroed.

// File: rtl/ent_pkg.sv
package ent_pkg;

    localparam int OSC_COUNT   = 128;
    localparam int GROUP_SIZE  = 8;
    localparam int GROUP_SEL_W = $clog2(OSC_COUNT / GROUP_SIZE);
    localparam int CTRL_W      = GROUP_SEL_W + 5;

    // Control register, LSB first: run, src_on, raw_out, rst_cond, rst_mem, grp
    typedef struct packed {
        logic [GROUP_SEL_W-1:0] grp;
        logic                   rst_mem;
        logic                   rst_cond;
        logic                   raw_out;
        logic                   src_on;
        logic                   run;
    } ctrl_t;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_DET  = 2'd1,
        MODE_COND = 2'd2,
        MODE_RAW  = 2'd3
    } mode_e;

    function automatic mode_e mode_of(input ctrl_t c);
        if (!c.run)        return MODE_OFF;
        else if (!c.src_on) return MODE_DET;
        else if (c.raw_out) return MODE_RAW;
        else                return MODE_COND;
    endfunction

    function automatic logic is_flush(input ctrl_t c);
        return c.rst_mem | c.rst_cond;
    endfunction

endpackage

// File: rtl/ent_ctrl_reg.sv
module ent_ctrl_reg
    import ent_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  ctrl_t wr_data,
    output ctrl_t ctrl_q,
    output logic  flush,
    output logic  restart
);

    ctrl_t nxt;

    always_comb begin
        nxt          = wr_data;
        nxt.rst_mem  = 1'b0;
        nxt.rst_cond = 1'b0;
        if (is_flush(wr_data))
            nxt = '0;
    end

    assign flush   = wr_en & is_flush(wr_data);
    assign restart = wr_en;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr_en)
            ctrl_q <= nxt;
    end

    // R2: a reset-bit write leaves the unit disabled
    a_r2_flush_disables: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_flush(wr_data)) |=> (ctrl_q == '0));

    // R2: reset bits never stick in the register
    a_r2_rst_bits_clear: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.rst_mem && !ctrl_q.rst_cond));

endmodule

// File: rtl/ent_producer.sv
module ent_producer
    import ent_pkg::*;
#(
    parameter int WORD_W   = 64,
    parameter int COND_LAT = 81
) (
    input  logic                   clk,
    input  logic                   rst,
    input  mode_e                  mode,
    input  logic [GROUP_SEL_W-1:0] grp,
    input  logic [OSC_COUNT-1:0]   osc_in,
    input  logic                   restart,
    input  logic                   full,
    input  logic [WORD_W-1:0]      cond_word,
    output logic                   push,
    output logic [WORD_W-1:0]      push_word,
    output logic                   cond_req,
    output logic                   cond_take,
    output logic                   cond_fixed
);

    localparam int SAMPLES = WORD_W / GROUP_SIZE;
    localparam int MAXC    = (COND_LAT > SAMPLES) ? COND_LAT : SAMPLES;
    localparam int CNT_W   = $clog2(MAXC);
    localparam int SEL_W   = $clog2(SAMPLES);
    localparam logic [CNT_W-1:0] RAW_LAST  = CNT_W'(SAMPLES - 1);
    localparam logic [CNT_W-1:0] COND_LAST = CNT_W'(COND_LAT - 1);

    logic [CNT_W-1:0]      cnt;
    logic [WORD_W-1:0]     shreg;
    logic [WORD_W-1:0]     packed_w;
    logic [GROUP_SIZE-1:0] osc_sel;
    logic [CNT_W-1:0]      last;
    logic                  is_raw;
    logic                  active;
    logic                  at_end;

    assign is_raw  = (mode == MODE_RAW);
    assign osc_sel = osc_in[grp*GROUP_SIZE +: GROUP_SIZE];
    assign last    = is_raw ? RAW_LAST : COND_LAST;
    assign active  = (mode != MODE_OFF) && !full && !restart;
    assign at_end  = active && (cnt == last);

    always_comb begin
        packed_w = shreg;
        packed_w[cnt[SEL_W-1:0]*GROUP_SIZE +: GROUP_SIZE] = osc_sel;
    end

    assign cond_req   = (mode == MODE_DET) || (mode == MODE_COND);
    assign cond_fixed = (mode == MODE_DET);
    assign cond_take  = at_end && cond_req;
    assign push       = at_end;
    assign push_word  = is_raw ? packed_w : cond_word;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (active) begin
            if (is_raw)
                shreg <= packed_w;
            cnt <= at_end ? '0 : cnt + 1'b1;
        end
    end

    // R10: a control write drops any partial word
    a_r10_restart_discards: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));

    // R7: nothing is produced into a full FIFO
    a_r7_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
        full |-> !push);

    // R6/R5: a disabled unit neither requests nor pushes
    a_r6_off_idle: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OFF) |-> (!push && !cond_req));

endmodule

// File: rtl/ent_fifo.sv
module ent_fifo #(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop,
    output logic              full,
    output logic [CW-1:0]     count,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid_q,
    output logic              underflow
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic              empty, real_pop, do_push;

    assign empty    = (count == '0);
    assign full     = (count == CW'(DEPTH));
    assign real_pop = pop && !empty;
    assign do_push  = push && !flush;

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wptr] <= push_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr       <= '0;
            rptr       <= '0;
            count      <= '0;
            rd_data    <= '0;
            rd_valid_q <= 1'b0;
            underflow  <= 1'b0;
        end else begin
            rd_valid_q <= pop;
            if (pop)
                rd_data <= real_pop ? mem[rptr] : '0;
            if (flush) begin
                wptr      <= '0;
                rptr      <= '0;
                count     <= '0;
                underflow <= 1'b0;
            end else begin
                if (do_push)
                    wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
                if (real_pop)
                    rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
                count <= count + CW'(do_push) - CW'(real_pop);
                if (pop && empty)
                    underflow <= 1'b1;
            end
        end
    end

    a_r7_bounded: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    a_r9_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !flush) |=> (rd_data == '0 && underflow));

    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        (underflow && !flush) |=> underflow);

    a_r8_data_next_cycle: assert property (@(posedge clk) disable iff (rst)
        pop |=> rd_valid_q);

    a_r2_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));

endmodule

// File: rtl/ent_fifo_unit.sv
module ent_fifo_unit
    import ent_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int WORD_W   = 64,
    parameter int COND_LAT = 81,
    parameter int BIST_W   = 8,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CTRL_W-1:0]    cfg_wdata,
    output logic [CTRL_W-1:0]    cfg_rdata,
    input  logic [OSC_COUNT-1:0] osc_in,
    input  logic                 rd_valid,
    output logic                 rd_ready,
    output logic [WORD_W-1:0]    rd_data,
    output logic                 rd_data_valid,
    output logic [CW-1:0]        fill_level,
    output logic                 underflow,
    output logic                 cond_req,
    output logic                 cond_fixed,
    output logic                 cond_take,
    input  logic [WORD_W-1:0]    cond_word,
    input  logic [BIST_W-1:0]    bist_raw,
    output logic [BIST_W-1:0]    bist_stat
);

    ctrl_t             ctrl_q;
    logic              flush, restart, full, push, pop;
    logic [WORD_W-1:0] push_word;
    mode_e             mode;

    assign rd_ready  = 1'b1;
    assign pop       = rd_valid & rd_ready;
    assign mode      = mode_of(ctrl_q);
    assign cfg_rdata = ctrl_q;

    ent_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_data (ctrl_t'(cfg_wdata)),
        .ctrl_q  (ctrl_q),
        .flush   (flush),
        .restart (restart)
    );

    ent_producer #(.WORD_W(WORD_W), .COND_LAT(COND_LAT)) u_prod (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .grp        (ctrl_q.grp),
        .osc_in     (osc_in),
        .restart    (restart),
        .full       (full),
        .cond_word  (cond_word),
        .push       (push),
        .push_word  (push_word),
        .cond_req   (cond_req),
        .cond_take  (cond_take),
        .cond_fixed (cond_fixed)
    );

    ent_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .push       (push),
        .push_word  (push_word),
        .pop        (pop),
        .full       (full),
        .count      (fill_level),
        .rd_data    (rd_data),
        .rd_valid_q (rd_data_valid),
        .underflow  (underflow)
    );

    always_ff @(posedge clk) begin
        if (rst)
            bist_stat <= '0;
        else
            bist_stat <= bist_raw;
    end

    // R11: status follows the raw result one cycle later
    a_r11_bist_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (bist_stat == $past(bist_raw)));

    // R6: fixed-input requests only happen as conditioner requests
    a_r6_fixed_is_request: assert property (@(posedge clk) disable iff (rst)
        cond_fixed |-> cond_req);

endmodule

// File: tb/ent_fifo_unit_test.sv
module ent_fifo_unit_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_we = 1'b0;
    logic [8:0]   cfg_wdata = '0;
    logic [8:0]   cfg_rdata;
    logic [127:0] osc_in = '0;
    logic         rd_valid = 1'b0;
    logic         rd_ready;
    logic [63:0]  rd_data;
    logic         rd_data_valid;
    logic [6:0]   fill_level;
    logic         underflow;
    logic         cond_req, cond_fixed, cond_take;
    logic [63:0]  cond_word = '0;
    logic [7:0]   bist_raw = '0;
    logic [7:0]   bist_stat;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    ent_fifo_unit uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .osc_in(osc_in), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .rd_data(rd_data), .rd_data_valid(rd_data_valid),
        .fill_level(fill_level), .underflow(underflow), .cond_req(cond_req),
        .cond_fixed(cond_fixed), .cond_take(cond_take), .cond_word(cond_word),
        .bist_raw(bist_raw), .bist_stat(bist_stat)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] cw(input int grp, input bit raw, input bit src,
                                      input bit run, input bit rcond, input bit rmem);
        return {grp[3:0], rmem, rcond, raw, src, run};
    endfunction

    function automatic logic [127:0] drive(input int grp, input logic [7:0] pat);
        logic [127:0] v;
        for (int g = 0; g < 16; g++) v[g*8 +: 8] = ~pat;
        v[grp*8 +: 8] = pat;
        return v;
    endfunction

    function automatic logic [7:0] pat_of(input int i);
        return 8'(i * 37 + 8'h5B);
    endfunction

    function automatic logic [63:0] pack(input int base);
        logic [63:0] w;
        for (int j = 0; j < 8; j++) w[j*8 +: 8] = pat_of(base + j);
        return w;
    endfunction

    task automatic cfg_write(input logic [8:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic flush_unit();
        cfg_write(cw(0, 0, 0, 0, 1, 1));
    endtask

    task automatic pop(output logic [63:0] d);
        rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
        d = rd_data;
        chk(rd_data_valid === 1'b1, "R8 data valid", 64'(rd_data_valid), 64'd1);
    endtask

    task automatic t_reset();
        chk(fill_level == 0, "R1 fill", 64'(fill_level), 0);
        chk(cfg_rdata == 0, "R1 ctrl", 64'(cfg_rdata), 0);
        chk(!rd_data_valid && !underflow && !cond_req, "R1 flags",
            64'({rd_data_valid, underflow, cond_req}), 0);
    endtask

    task automatic t_raw_pack();
        logic [63:0] d;
        flush_unit();
        cfg_write(cw(5, 1, 1, 1, 0, 0));
        chk(cfg_rdata == cw(5, 1, 1, 1, 0, 0), "R2 readback", 64'(cfg_rdata),
            64'(cw(5, 1, 1, 1, 0, 0)));
        for (int i = 0; i < 16; i++) begin
            osc_in = drive(5, pat_of(i));
            @(negedge clk);
        end
        chk(fill_level == 2, "R4 two words", 64'(fill_level), 2);
        pop(d);
        chk(d == pack(0), "R3 first word", d, pack(0));
        pop(d);
        chk(d == pack(8), "R8 order second word", d, pack(8));
    endtask

    task automatic t_raw_rate();
        flush_unit();
        cfg_write(cw(1, 1, 1, 1, 0, 0));
        repeat (7) @(negedge clk);
        chk(fill_level == 0, "R4 before 8th edge", 64'(fill_level), 0);
        @(negedge clk);
        chk(fill_level == 1, "R4 at 8th edge", 64'(fill_level), 1);
        repeat (31) @(negedge clk);
        chk(fill_level == 4, "R4 before 5th word", 64'(fill_level), 4);
        @(negedge clk);
        chk(fill_level == 5, "R4 5th word", 64'(fill_level), 5);
    endtask

    task automatic t_fill();
        flush_unit();
        cfg_write(cw(0, 1, 1, 1, 0, 0));
        repeat (8 * 64 + 16) @(negedge clk);
        chk(fill_level == 64, "R7 full", 64'(fill_level), 64);
        rd_valid = 1'b1;
        repeat (3) @(negedge clk);
        rd_valid = 1'b0;
        chk(fill_level == 61, "R7 after reads", 64'(fill_level), 61);
        repeat (40) @(negedge clk);
        chk(fill_level == 64, "R7 refilled", 64'(fill_level), 64);
        chk(underflow == 0, "R9 no underflow", 64'(underflow), 0);
    endtask

    task automatic t_cond();
        logic [63:0] d;
        flush_unit();
        cond_word = 64'hC0DE_1234_F00D_5678;
        cfg_write(cw(0, 0, 1, 1, 0, 0));
        repeat (80) @(negedge clk);
        chk(fill_level == 0, "R5 before latency", 64'(fill_level), 0);
        chk(cond_req && cond_take && !cond_fixed, "R5 req/take",
            64'({cond_req, cond_take, cond_fixed}), 64'b110);
        @(negedge clk);
        chk(fill_level == 1, "R5 word in", 64'(fill_level), 1);
        chk(cond_take == 0, "R5 take drop", 64'(cond_take), 0);
        pop(d);
        chk(d == 64'hC0DE_1234_F00D_5678, "R5 word", d, 64'hC0DE_1234_F00D_5678);
    endtask

    task automatic t_det();
        logic [63:0] d;
        flush_unit();
        cond_word = 64'h0123_4567_89AB_CDEF;
        cfg_write(cw(7, 1, 0, 1, 0, 0));
        for (int i = 0; i < 81; i++) begin
            osc_in = {4{32'(i * 7919)}};
            @(negedge clk);
        end
        chk(fill_level == 1 && cond_fixed, "R6 det word",
            64'({fill_level, cond_fixed}), 64'({7'd1, 1'b1}));
        pop(d);
        chk(d == 64'h0123_4567_89AB_CDEF, "R6 osc ignored", d, 64'h0123_4567_89AB_CDEF);
    endtask

    task automatic t_off();
        flush_unit();
        cfg_write(cw(3, 1, 1, 0, 0, 0));
        repeat (100) @(negedge clk);
        chk(fill_level == 0 && !cond_req, "R6 disabled idle",
            64'({fill_level, cond_req}), 0);
    endtask

    task automatic t_underflow();
        logic [63:0] d;
        flush_unit();
        chk(underflow == 0, "R2 flush clears flag", 64'(underflow), 0);
        pop(d);
        chk(d == 0, "R9 zero data", d, 0);
        chk(underflow == 1, "R9 flag set", 64'(underflow), 1);
        repeat (5) @(negedge clk);
        chk(underflow == 1 && !rd_data_valid, "R9 sticky",
            64'({underflow, rd_data_valid}), 64'b10);
        flush_unit();
        chk(underflow == 0 && cfg_rdata == 0, "R2 flush",
            64'({underflow, cfg_rdata}), 0);
    endtask

    task automatic t_discard();
        logic [63:0] d;
        logic [63:0] exp;
        flush_unit();
        cfg_write(cw(2, 1, 1, 1, 0, 0));
        for (int i = 0; i < 4; i++) begin
            osc_in = drive(2, pat_of(100 + i));
            @(negedge clk);
        end
        cfg_write(cw(3, 1, 1, 1, 0, 0));
        chk(fill_level == 0, "R10 no partial push", 64'(fill_level), 0);
        for (int i = 0; i < 8; i++) begin
            osc_in = drive(3, pat_of(200 + i));
            @(negedge clk);
        end
        exp = pack(200);
        chk(fill_level == 1, "R10 one word", 64'(fill_level), 1);
        pop(d);
        chk(d == exp, "R10 fresh word", d, exp);
    endtask

    task automatic t_bist();
        bist_raw = 8'h00;
        @(negedge clk);
        chk(bist_stat == 0, "R11 pass", 64'(bist_stat), 0);
        bist_raw = 8'h5A;
        @(negedge clk);
        chk(bist_stat == 8'h5A, "R11 fail bits", 64'(bist_stat), 64'h5A);
        bist_raw = 8'h00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_raw_pack();
        t_raw_rate();
        t_fill();
        t_cond();
        t_det();
        t_off();
        t_underflow();
        t_discard();
        t_bist();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule